// File: doc/BRIEF.md
# Cache Tag Global Invalidation Sequencer

This block clears a whole cache tag array when software asks it to. A write that sets the invalidate bit starts a hardware walk over the tag array. The walk zeroes one entry per clock: the address tag, the valid and dirty status bits and the replacement FIFO bit. While the walk runs, a read-only in-progress flag is high. A stall output also holds off every first-level instruction and data request, so none of them can reach the tags.

A clear is only allowed while the cache enable bit is low. A request made with the cache enabled does not start a walk. Instead it sets a sticky error flag, which stays set until software clears it. The tag store keeps its contents across a hard reset. Software must therefore run one invalidation before it first turns the cache on. Outside a walk, the normal fill port of the cache controller writes the tag store directly. Lookups compare the stored tag combinationally.

Top module: `tag_inv_top`

## Requirements
- R1: After reset, `busy`, `inv_bit`, `err`, `stall` and `tag_we` are all 0.
- R2: A pulse on `inv_set` while `cfg_en` is 0 and no walk is running starts a walk. From the next cycle, `busy`, `inv_bit` and `stall` are 1, and the write port writes index 0, then one index higher each cycle up to DEPTH-1.
- R3: Every write issued by the walk carries tag 0, valid 0, dirty 0 and FIFO 0. After the walk, every index looks up as a miss.
- R4: `busy` is high for exactly DEPTH cycles and falls in the cycle after the write to index DEPTH-1. `inv_bit` clears at the same edge.
- R5: A pulse on `inv_set` while `cfg_en` is 1 and no walk is running is ignored. No walk starts, `inv_bit` stays 0 and stored tags keep hitting. `err` is 1 from the next cycle.
- R6: `err` stays set until a pulse on `err_clr`, which clears it for the next cycle. If a rejected request and `err_clr` arrive in the same cycle, `err` stays set.
- R7: While `stall` is 1, fill writes are ignored, the write port index follows the walk, and `lk_hit` is 0.
- R8: Raising `cfg_en` during a walk does not stop it. The walk still runs for DEPTH cycles.
- R9: A pulse on `inv_set` during a walk is ignored. It does not restart the walk and does not set `err`.
- R10: Reset does not alter the tag store. An entry written before a reset still hits after it.
- R11: Outside a walk, a fill write stores tag, valid, dirty and FIFO at its index. A lookup hits when the entry is valid and its tag equals `lk_tag`, and `lk_dirty` then shows the stored dirty bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Cache enable bit |
| inv_set | input | 1 | One-cycle write of 1 to the invalidate bit |
| err_clr | input | 1 | One-cycle clear of the error flag |
| fill_we | input | 1 | Fill write strobe from the cache controller |
| fill_idx | input | IDX_W | Fill write index |
| fill_tag | input | TAG_W | Fill tag |
| fill_valid | input | 1 | Fill valid bit |
| fill_dirty | input | 1 | Fill dirty bit |
| fill_fifo | input | 1 | Fill replacement FIFO bit |
| lk_idx | input | IDX_W | Lookup index from first-level caches |
| lk_tag | input | TAG_W | Lookup tag to compare |
| lk_hit | output | 1 | Lookup hit, forced low during a walk |
| lk_dirty | output | 1 | Dirty bit of a hitting entry |
| tag_we | output | 1 | Tag array write strobe |
| tag_widx | output | IDX_W | Tag array write index |
| tag_wtag | output | TAG_W | Tag array write tag |
| tag_wvalid | output | 1 | Tag array write valid bit |
| tag_wdirty | output | 1 | Tag array write dirty bit |
| tag_wfifo | output | 1 | Tag array write FIFO bit |
| inv_bit | output | 1 | Invalidate bit readback, cleared when the walk ends |
| busy | output | 1 | Read-only in-progress flag |
| err | output | 1 | Sticky flag for a request made while enabled |
| stall | output | 1 | Holds off first-level requests during a walk |

## Verification
The assertions assume that `inv_set` and `err_clr` are single-cycle pulses, and that reset is held for at least one clock edge before any check counts. The bench therefore drives every control pulse for exactly one cycle, on the falling edge. The assertions also assume that fill writes and lookups may arrive at any time, including during a walk. The stimulus makes use of that: it injects a fill write, a lookup of a still-valid entry, a repeat request and an enable rise in the middle of a walk.

// File: rtl/tinv_pkg.sv
package tinv_pkg;

    parameter int unsigned TAG_W = 20;
    parameter int unsigned IDX_W = 8;
    localparam int unsigned DEPTH = 1 << IDX_W;

    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef struct packed {
        tag_t tag;
        logic valid;
        logic dirty;
        logic fifo;
    } tag_entry_t;

    typedef struct packed {
        logic       we;
        idx_t       idx;
        tag_entry_t entry;
    } tag_wr_t;

    typedef enum logic [1:0] {
        SWP_IDLE = 2'd0,
        SWP_RUN  = 2'd1
    } swp_state_e;

    localparam idx_t LAST_IDX = idx_t'(DEPTH - 1);

    function automatic logic idx_is_last(input idx_t i);
        return i == LAST_IDX;
    endfunction

    function automatic logic tag_match(input tag_entry_t e, input tag_t t);
        return e.valid && (e.tag == t);
    endfunction

    function automatic tag_entry_t cleared_entry();
        tag_entry_t e;
        e.tag   = '0;
        e.valid = 1'b0;
        e.dirty = 1'b0;
        e.fifo  = 1'b0;
        return e;
    endfunction

endpackage

// File: rtl/tinv_ctrl.sv
module tinv_ctrl
    import tinv_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cfg_en,
    input  logic    inv_set,
    input  logic    err_clr,
    output logic    busy,
    output logic    inv_bit,
    output logic    err,
    output tag_wr_t sweep_wr
);

    swp_state_e state_q;
    idx_t       idx_q;
    logic       inv_q;
    logic       err_q;
    logic       accept;
    logic       reject;

    // A request is only acted on when no walk is running
    assign accept = (state_q == SWP_IDLE) && inv_set && !cfg_en;
    assign reject = (state_q == SWP_IDLE) && inv_set && cfg_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SWP_IDLE;
            idx_q   <= '0;
            inv_q   <= 1'b0;
        end else begin
            unique case (state_q)
                SWP_IDLE: begin
                    if (accept) begin
                        state_q <= SWP_RUN;
                        idx_q   <= '0;
                        inv_q   <= 1'b1;
                    end
                end
                SWP_RUN: begin
                    if (idx_is_last(idx_q)) begin
                        state_q <= SWP_IDLE;
                        idx_q   <= '0;
                        inv_q   <= 1'b0;
                    end else begin
                        idx_q <= idx_q + idx_t'(1);
                    end
                end
                default: begin
                    state_q <= SWP_IDLE;
                    idx_q   <= '0;
                    inv_q   <= 1'b0;
                end
            endcase
        end
    end

    // Sticky error: a new rejection wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (reject) begin
            err_q <= 1'b1;
        end else if (err_clr) begin
            err_q <= 1'b0;
        end
    end

    assign busy    = (state_q == SWP_RUN);
    assign inv_bit = inv_q;
    assign err     = err_q;

    always_comb begin
        sweep_wr.we    = busy;
        sweep_wr.idx   = idx_q;
        sweep_wr.entry = cleared_entry();
    end

    // R2
    start_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && inv_set && !cfg_en) |=> (busy && inv_bit && idx_q == '0));

    // R4
    busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && idx_is_last(idx_q)) |=> (!busy && !inv_bit));

    // R8
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !idx_is_last(idx_q)) |=> (busy && idx_q == $past(idx_q) + idx_t'(1)));

    // R5
    reject_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && inv_set && cfg_en) |=> (!busy && !inv_bit && err));

    // R6
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (err && !err_clr) |=> err);

endmodule

// File: rtl/tinv_wrmux.sv
module tinv_wrmux
    import tinv_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  tag_wr_t sweep_wr,
    input  tag_wr_t fill_wr,
    output tag_wr_t out_wr,
    output logic    stall
);

    assign stall = sweep_wr.we;

    always_comb begin
        if (stall) begin
            out_wr = sweep_wr;
        end else begin
            out_wr = fill_wr;
        end
    end

    // R7
    fill_block_chk: assert property (@(posedge clk) disable iff (rst)
        (stall && fill_wr.we) |-> (out_wr.idx == sweep_wr.idx && !out_wr.entry.valid));

    // R3
    zero_wr_chk: assert property (@(posedge clk) disable iff (rst)
        stall |-> (out_wr.we && out_wr.entry.tag == '0 && !out_wr.entry.dirty && !out_wr.entry.fifo));

endmodule

// File: rtl/tinv_store.sv
module tinv_store
    import tinv_pkg::*;
(
    input  logic       clk,
    input  tag_wr_t    wr,
    input  idx_t       rd_idx,
    output tag_entry_t rd_entry
);

    // Contents are deliberately left without reset
    tag_entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr.we) begin
            mem[wr.idx] <= wr.entry;
        end
    end

    assign rd_entry = mem[rd_idx];

endmodule

// File: rtl/tag_inv_top.sv
module tag_inv_top
    import tinv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             inv_set,
    input  logic             err_clr,
    input  logic             fill_we,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             fill_valid,
    input  logic             fill_dirty,
    input  logic             fill_fifo,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic             lk_dirty,
    output logic             tag_we,
    output logic [IDX_W-1:0] tag_widx,
    output logic [TAG_W-1:0] tag_wtag,
    output logic             tag_wvalid,
    output logic             tag_wdirty,
    output logic             tag_wfifo,
    output logic             inv_bit,
    output logic             busy,
    output logic             err,
    output logic             stall
);

    tag_wr_t    sweep_wr;
    tag_wr_t    fill_wr;
    tag_wr_t    arr_wr;
    tag_entry_t rd_entry;

    always_comb begin
        fill_wr.we          = fill_we;
        fill_wr.idx         = fill_idx;
        fill_wr.entry.tag   = fill_tag;
        fill_wr.entry.valid = fill_valid;
        fill_wr.entry.dirty = fill_dirty;
        fill_wr.entry.fifo  = fill_fifo;
    end

    tinv_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .cfg_en   (cfg_en),
        .inv_set  (inv_set),
        .err_clr  (err_clr),
        .busy     (busy),
        .inv_bit  (inv_bit),
        .err      (err),
        .sweep_wr (sweep_wr)
    );

    tinv_wrmux u_mux (
        .clk      (clk),
        .rst      (rst),
        .sweep_wr (sweep_wr),
        .fill_wr  (fill_wr),
        .out_wr   (arr_wr),
        .stall    (stall)
    );

    tinv_store u_store (
        .clk      (clk),
        .wr       (arr_wr),
        .rd_idx   (lk_idx),
        .rd_entry (rd_entry)
    );

    assign tag_we     = arr_wr.we;
    assign tag_widx   = arr_wr.idx;
    assign tag_wtag   = arr_wr.entry.tag;
    assign tag_wvalid = arr_wr.entry.valid;
    assign tag_wdirty = arr_wr.entry.dirty;
    assign tag_wfifo  = arr_wr.entry.fifo;

    assign lk_hit   = !stall && tag_match(rd_entry, lk_tag);
    assign lk_dirty = lk_hit && rd_entry.dirty;

    // R7
    no_hit_stall_chk: assert property (@(posedge clk) disable iff (rst)
        stall |-> !lk_hit);

    // R1
    rst_idle_chk: assert property (@(posedge clk)
        rst |=> (!busy && !err && !inv_bit && !tag_we));

endmodule

// File: tb/tag_inv_top_tb.sv
`timescale 1ns/1ps
module tag_inv_top_tb;
    import tinv_pkg::*;

    logic clk = 1'b0;
    logic rst, cfg_en, inv_set, err_clr;
    logic fill_we, fill_valid, fill_dirty, fill_fifo;
    logic [IDX_W-1:0] fill_idx, lk_idx, tag_widx;
    logic [TAG_W-1:0] fill_tag, lk_tag, tag_wtag;
    logic lk_hit, lk_dirty, tag_we, tag_wvalid, tag_wdirty, tag_wfifo;
    logic inv_bit, busy, err, stall;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    tag_inv_top u_dut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .inv_set(inv_set), .err_clr(err_clr),
        .fill_we(fill_we), .fill_idx(fill_idx), .fill_tag(fill_tag),
        .fill_valid(fill_valid), .fill_dirty(fill_dirty), .fill_fifo(fill_fifo),
        .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_dirty(lk_dirty),
        .tag_we(tag_we), .tag_widx(tag_widx), .tag_wtag(tag_wtag),
        .tag_wvalid(tag_wvalid), .tag_wdirty(tag_wdirty), .tag_wfifo(tag_wfifo),
        .inv_bit(inv_bit), .busy(busy), .err(err), .stall(stall)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic fill(input int idx, input logic [TAG_W-1:0] t, input logic d);
        @(negedge clk);
        fill_we = 1'b1; fill_idx = IDX_W'(idx); fill_tag = t;
        fill_valid = 1'b1; fill_dirty = d; fill_fifo = 1'b1;
        @(negedge clk);
        fill_we = 1'b0;
    endtask

    task automatic lookup(input int idx, input logic [TAG_W-1:0] t);
        lk_idx = IDX_W'(idx); lk_tag = t;
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !inv_bit && !err && !stall && !tag_we, "R1 idle after reset",
            {busy, inv_bit, err, stall, tag_we}, 0);
    endtask

    task automatic t_fill_persist();
        fill(3, 20'h00A5A, 1'b1);
        lookup(3, 20'h00A5A);
        chk(lk_hit && lk_dirty, "R11 fill then hit dirty", {lk_hit, lk_dirty}, 2'b11);
        lookup(3, 20'h00A5B);
        chk(!lk_hit, "R11 tag mismatch misses", lk_hit, 0);
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        lookup(3, 20'h00A5A);
        chk(lk_hit, "R10 tag survives reset", lk_hit, 1);
    endtask

    task automatic t_reject();
        fill(0, 20'h11111, 1'b0);
        fill(255, 20'h22222, 1'b1);
        @(negedge clk) cfg_en = 1'b1; inv_set = 1'b1;
        @(negedge clk) inv_set = 1'b0;
        chk(!busy && !inv_bit && !stall && err, "R5 rejected while enabled",
            {busy, inv_bit, stall, err}, 1);
        lookup(0, 20'h11111);
        chk(lk_hit, "R5 tags untouched", lk_hit, 1);
        repeat (3) @(negedge clk);
        chk(err, "R6 err sticky", err, 1);
        inv_set = 1'b1; err_clr = 1'b1;
        @(negedge clk) inv_set = 1'b0; err_clr = 1'b0;
        chk(err, "R6 set wins over clear", err, 1);
        err_clr = 1'b1;
        @(negedge clk) err_clr = 1'b0;
        chk(!err, "R6 err cleared", err, 0);
        cfg_en = 1'b0;
    endtask

    task automatic t_sweep();
        int bad_idx = 0;
        int bad_dat = 0;
        int bad_stall = 0;
        int bad_hit = 0;
        @(negedge clk) inv_set = 1'b1;
        @(negedge clk) inv_set = 1'b0;
        chk(busy && inv_bit && stall, "R2 walk started", {busy, inv_bit, stall}, 3'b111);
        for (int k = 0; k < DEPTH; k++) begin
            if (!tag_we || tag_widx != IDX_W'(k)) bad_idx++;
            if (tag_wtag != '0 || tag_wvalid || tag_wdirty || tag_wfifo) bad_dat++;
            if (!stall || !busy) bad_stall++;
            if (k == 7) begin
                lookup(255, 20'h22222);
                if (lk_hit) bad_hit++;
            end
            inv_set = (k == 10);
            fill_we = (k == 200);
            fill_idx = 8'd5; fill_tag = 20'hABCDE;
            fill_valid = 1'b1; fill_dirty = 1'b1; fill_fifo = 1'b1;
            @(negedge clk);
        end
        inv_set = 1'b0; fill_we = 1'b0;
        chk(bad_idx == 0, "R2 ascending index per cycle", bad_idx, 0);
        chk(bad_dat == 0, "R3 zero write data", bad_dat, 0);
        chk(bad_stall == 0, "R7 stall whole walk", bad_stall, 0);
        chk(bad_hit == 0, "R7 no hit during stall", bad_hit, 0);
        chk(!busy && !inv_bit && !stall, "R4 busy falls after last write",
            {busy, inv_bit, stall}, 0);
        chk(!err, "R9 repeat request no error", err, 0);
        bad_hit = 0;
        for (int i = 0; i < DEPTH; i++) begin
            lookup(i, (i == 5) ? 20'hABCDE : (i == 255) ? 20'h22222 : 20'h0);
            if (lk_hit) bad_hit++;
        end
        chk(bad_hit == 0, "R3 R7 all entries miss after walk", bad_hit, 0);
        @(negedge clk);
        chk(!busy, "R9 no restart", busy, 0);
    endtask

    task automatic t_enable_mid();
        int cyc = 0;
        @(negedge clk) inv_set = 1'b1;
        @(negedge clk) inv_set = 1'b0;
        while (busy && cyc < 2 * DEPTH) begin
            if (cyc == 3) cfg_en = 1'b1;
            cyc++;
            @(negedge clk);
        end
        chk(cyc == DEPTH, "R8 walk completes with enable raised", cyc, DEPTH);
        chk(!err, "R8 no error", err, 0);
        cfg_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_en = 1'b0; inv_set = 1'b0; err_clr = 1'b0;
        fill_we = 1'b0; fill_idx = '0; fill_tag = '0;
        fill_valid = 1'b0; fill_dirty = 1'b0; fill_fifo = 1'b0;
        lk_idx = '0; lk_tag = '0;
        t_reset();
        t_fill_persist();
        t_reject();
        t_sweep();
        t_enable_mid();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule